// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

This block sits between the three rotor-position sensors of a three-phase brushless motor and the gate drivers. It reads a 3-bit sensor code and produces six drive enables. Three are high-side (top) drives and three are low-side (bottom) drives. In normal running, exactly one top drive and one bottom drive are on, and they are on different phases. The sensor code picks which pair. A mode input chooses how the code is read: 60-degree or 120-degree sensor spacing. A direction input reverses rotation by exchanging the phases that the top and bottom drives select. Speed control is applied as a PWM gate that chops only the bottom drive.

Brake, enable, sensor validity and an external fault request are resolved in a fixed order of priority. This order sets both the drive pattern and the level of the active-low fault output. Braking turns on every bottom drive, which shorts the windings to the low rail. Every output is registered on the system clock, so a change on any input reaches the pins one clock edge later.

Top module: `hallCommutator`

## Requirements
- R1: While rst_n is low, all six drives are off and faultN is low.
- R2: Every output is registered: an input change made between edges shows at the outputs only after the next rising clock edge.
- R3: With phase60=0 (120-degree mode), dirFwd=1, enableIn=1, brakeReq=0, extFault=0 and pwmGate=1, each hallIn[2:0] code sets {top phase, bottom phase} and faultN=1 as follows: 101→{A,B}, 100→{A,C}, 110→{B,C}, 010→{B,A}, 011→{C,A}, 001→{C,B}. Phase A is bit 0, phase B is bit 1 and phase C is bit 2 of topDrv and botDrv.
- R4: Under the same conditions with phase60=1 (60-degree mode), the codes map as: 100→{A,B}, 110→{A,C}, 111→{B,C}, 011→{B,A}, 001→{C,A}, 000→{C,B}.
- R5: dirFwd=0 exchanges the top and bottom phases of the step that R3 or R4 gives.
- R6: During normal commutation, the bottom drive is on only while pwmGate=1. The top drive does not depend on pwmGate.
- R7: An invalid code (000 or 111 in 120-degree mode, 010 or 101 in 60-degree mode) with enableIn=1 and brakeReq=0 turns all drives off and drives faultN low.
- R8: An invalid code with brakeReq=1 and enableIn=1 turns all tops off and all bottoms on, and drives faultN low.
- R9: A valid code with brakeReq=1 and enableIn=1 turns all tops off and all bottoms on, regardless of pwmGate, and leaves faultN high.
- R10: enableIn=0 with brakeReq=1 turns all tops off and all bottoms on, and drives faultN low.
- R11: enableIn=0 with brakeReq=0 turns all six drives off and drives faultN low.
- R12: extFault=1 forces all bottom drives off and faultN low. This overrides every other case. The top drives still follow the other rules.
- R13: A top drive and the bottom drive of the same phase are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hallIn | input | 3 | Sensor code |
| phase60 | input | 1 | 1 = 60-degree, 0 = 120-degree sensor spacing |
| dirFwd | input | 1 | 1 = forward step order, 0 = reversed |
| brakeReq | input | 1 | Brake request |
| enableIn | input | 1 | Drive enable |
| extFault | input | 1 | External fault request |
| pwmGate | input | 1 | PWM chop applied to the bottom drive |
| topDrv | output | 3 | High-side drives, bit 0 = phase A |
| botDrv | output | 3 | Low-side drives, bit 0 = phase A |
| faultN | output | 1 | Active-low fault flag |

## Verification
The bench targets the codes that are valid in one mode and invalid in the other (101, 000, 111, 010). A decoder that ignores the mode would drive a commutation step where it should flag a fault. Brake is tested with both valid and invalid codes, because a design that inverts the validity term would report the fault level wrongly while still braking. The bench drives pwmGate low during braking and during commutation, which exposes chopping applied to the wrong drive. It also raises extFault together with brake, so a design that lets brake win would leave the bottoms on. Latency is checked by sampling before and after the clock edge, to catch a combinational path to the pins.

// File: rtl/hallCommPkg.sv
package hallCommPkg;
  localparam int NUM_PHASE = 3;
  localparam int HALL_W    = 3;
  localparam int NUM_STEP  = 2 * NUM_PHASE;
  localparam int STEP_W    = $clog2(NUM_STEP);
  localparam int PH_W      = $clog2(NUM_PHASE);

  typedef logic [NUM_PHASE-1:0] driveVec_t;

  typedef struct packed {
    logic topEn;       // one top drive may be on
    logic botAll;      // every bottom drive on (brake)
    logic botComm;     // bottom drive follows commutation step
    logic killBot;     // bottom drives forced off
    logic faultAssert; // fault output active
  } ctrlStrobe_t;
endpackage

// File: rtl/hallStepDecoder.sv
module hallStepDecoder
  import hallCommPkg::*;
(
  input  logic [HALL_W-1:0] hallIn,
  input  logic              phase60,
  output logic [STEP_W-1:0] stepIdx,
  output logic              codeValid
);
  always_comb begin
    stepIdx   = '0;
    codeValid = 1'b1;
    if (phase60) begin
      unique case (hallIn)
        3'b100:  stepIdx = STEP_W'(0);
        3'b110:  stepIdx = STEP_W'(1);
        3'b111:  stepIdx = STEP_W'(2);
        3'b011:  stepIdx = STEP_W'(3);
        3'b001:  stepIdx = STEP_W'(4);
        3'b000:  stepIdx = STEP_W'(5);
        default: codeValid = 1'b0;
      endcase
    end else begin
      unique case (hallIn)
        3'b101:  stepIdx = STEP_W'(0);
        3'b100:  stepIdx = STEP_W'(1);
        3'b110:  stepIdx = STEP_W'(2);
        3'b010:  stepIdx = STEP_W'(3);
        3'b011:  stepIdx = STEP_W'(4);
        3'b001:  stepIdx = STEP_W'(5);
        default: codeValid = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/commControl.sv
module commControl
  import hallCommPkg::*;
(
  input  logic        codeValid,
  input  logic        brakeReq,
  input  logic        enableIn,
  input  logic        extFault,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (!enableIn) begin
      strobe.botAll      = brakeReq;
      strobe.faultAssert = 1'b1;
    end else if (brakeReq) begin
      strobe.botAll      = 1'b1;
      strobe.faultAssert = !codeValid;
    end else if (!codeValid) begin
      strobe.faultAssert = 1'b1;
    end else begin
      strobe.topEn   = 1'b1;
      strobe.botComm = 1'b1;
    end
    // external request overrides the bottom side and the flag
    if (extFault) begin
      strobe.killBot     = 1'b1;
      strobe.faultAssert = 1'b1;
    end
  end
endmodule

// File: rtl/driveDatapath.sv
module driveDatapath
  import hallCommPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              dirFwd,
  input  logic              pwmGate,
  input  ctrlStrobe_t       strobe,
  output driveVec_t         topDrv,
  output driveVec_t         botDrv,
  output logic              faultN
);
  logic [PH_W-1:0]   leadPh;
  logic [PH_W-1:0]   trailPh;
  logic [PH_W:0]     trailSum;
  logic [PH_W-1:0]   selTop;
  logic [PH_W-1:0]   selBot;
  driveVec_t         topNext;
  driveVec_t         botNext;

  always_comb begin
    leadPh   = PH_W'(stepIdx >> 1);
    trailSum = (PH_W+1)'(leadPh) + (PH_W+1)'(1) + (PH_W+1)'(stepIdx[0]);
    if (trailSum >= (PH_W+1)'(NUM_PHASE)) trailSum = trailSum - (PH_W+1)'(NUM_PHASE);
    trailPh  = PH_W'(trailSum);
    selTop   = dirFwd ? leadPh  : trailPh;
    selBot   = dirFwd ? trailPh : leadPh;
  end

  for (genvar g = 0; g < NUM_PHASE; g++) begin : g_phase
    always_comb begin
      topNext[g] = strobe.topEn && (selTop == PH_W'(g));
      if (strobe.killBot)      botNext[g] = 1'b0;
      else if (strobe.botAll)  botNext[g] = 1'b1;
      else                     botNext[g] = strobe.botComm && pwmGate && (selBot == PH_W'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topDrv <= '0;
      botDrv <= '0;
      faultN <= 1'b0;
    end else begin
      topDrv <= topNext;
      botDrv <= botNext;
      faultN <= !strobe.faultAssert;
    end
  end
endmodule

// File: rtl/hallCommutator.sv
module hallCommutator
  import hallCommPkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  hallIn,
  input  logic        phase60,
  input  logic        dirFwd,
  input  logic        brakeReq,
  input  logic        enableIn,
  input  logic        extFault,
  input  logic        pwmGate,
  output logic [2:0]  topDrv,
  output logic [2:0]  botDrv,
  output logic        faultN
);
  logic [STEP_W-1:0] stepIdx;
  logic              codeValid;
  ctrlStrobe_t       strobe;

  hallStepDecoder u_dec (
    .hallIn(hallIn), .phase60(phase60), .stepIdx(stepIdx), .codeValid(codeValid)
  );

  commControl u_ctrl (
    .codeValid(codeValid), .brakeReq(brakeReq), .enableIn(enableIn),
    .extFault(extFault), .strobe(strobe)
  );

  driveDatapath u_dp (
    .clk(clk), .rst_n(rst_n), .stepIdx(stepIdx), .dirFwd(dirFwd),
    .pwmGate(pwmGate), .strobe(strobe), .topDrv(topDrv), .botDrv(botDrv),
    .faultN(faultN)
  );
endmodule

// File: rtl/hallCommChecker.sv
module hallCommChecker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hallIn,
  input logic       phase60,
  input logic       dirFwd,
  input logic       brakeReq,
  input logic       enableIn,
  input logic       extFault,
  input logic       pwmGate,
  input logic [2:0] topDrv,
  input logic [2:0] botDrv,
  input logic       faultN
);
  a_r13_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (topDrv & botDrv) == 3'b000);

  a_r3_single_top: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(topDrv));

  a_r12_ext_fault: assert property (@(posedge clk) disable iff (!rst_n)
    extFault |=> (botDrv == 3'b000) && !faultN);

  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enableIn |=> (topDrv == 3'b000) && !faultN);

  a_r9_brake_bottoms: assert property (@(posedge clk) disable iff (!rst_n)
    (brakeReq && !extFault) |=> (topDrv == 3'b000) && (botDrv == 3'b111));

  a_r6_pwm_chop: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwmGate && !brakeReq) |=> botDrv == 3'b000);
endmodule

bind hallCommutator hallCommChecker u_chk (.*);

// File: tb/sim_hallCommutator.sv
module sim_hallCommutator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hallIn = 3'b000;
  logic       phase60 = 1'b0, dirFwd = 1'b1, brakeReq = 1'b0;
  logic       enableIn = 1'b0, extFault = 1'b0, pwmGate = 1'b1;
  logic [2:0] topDrv, botDrv;
  logic       faultN;
  int         nChecks = 0, nFail = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  hallCommutator u0 (
    .clk(clk), .rst_n(rst_n), .hallIn(hallIn), .phase60(phase60), .dirFwd(dirFwd),
    .brakeReq(brakeReq), .enableIn(enableIn), .extFault(extFault), .pwmGate(pwmGate),
    .topDrv(topDrv), .botDrv(botDrv), .faultN(faultN)
  );

  // entry: mode | hall(3) | dir | brake | en | ext | pwm | top(3) | bot(3) | faultN | req(4)
  localparam int NV = 25;
  localparam logic [19:0] VEC [NV] = '{
    20'b0_101_1_0_1_0_1_001_010_1_0011, // R3
    20'b0_100_1_0_1_0_1_001_100_1_0011, // R3
    20'b0_110_1_0_1_0_1_010_100_1_0011, // R3
    20'b0_010_1_0_1_0_1_010_001_1_0011, // R3
    20'b0_011_1_0_1_0_1_100_001_1_0011, // R3
    20'b0_001_1_0_1_0_1_100_010_1_0011, // R3
    20'b1_100_1_0_1_0_1_001_010_1_0100, // R4
    20'b1_110_1_0_1_0_1_001_100_1_0100, // R4
    20'b1_111_1_0_1_0_1_010_100_1_0100, // R4
    20'b1_011_1_0_1_0_1_010_001_1_0100, // R4
    20'b1_001_1_0_1_0_1_100_001_1_0100, // R4
    20'b1_000_1_0_1_0_1_100_010_1_0100, // R4
    20'b0_101_0_0_1_0_1_010_001_1_0101, // R5
    20'b1_011_0_0_1_0_1_001_010_1_0101, // R5
    20'b0_110_1_0_1_0_0_010_000_1_0110, // R6
    20'b0_000_1_0_1_0_1_000_000_0_0111, // R7
    20'b0_111_1_0_1_0_1_000_000_0_0111, // R7
    20'b1_010_1_0_1_0_1_000_000_0_0111, // R7
    20'b1_101_1_0_1_0_1_000_000_0_0111, // R7
    20'b0_111_1_1_1_0_1_000_111_0_1000, // R8
    20'b0_100_1_1_1_0_0_000_111_1_1001, // R9
    20'b1_111_1_1_0_0_1_000_111_0_1010, // R10
    20'b0_100_1_0_0_0_1_000_000_0_1011, // R11
    20'b0_011_1_0_1_1_1_100_000_0_1100, // R12
    20'b0_101_1_1_1_1_1_000_000_0_1100  // R12
  };

  task automatic check(input string req, input logic [2:0] eT, input logic [2:0] eB, input logic eF);
    nChecks++;
    if (topDrv !== eT || botDrv !== eB || faultN !== eF) begin
      nFail++;
      $display("FAIL %s: top=%b bot=%b faultN=%b expected top=%b bot=%b faultN=%b",
               req, topDrv, botDrv, faultN, eT, eB, eF);
    end
  endtask

  task automatic applyVec(input logic [19:0] v);
    {phase60, hallIn, dirFwd, brakeReq, enableIn, extFault, pwmGate} = v[19:11];
  endtask

  initial begin
    // R1: reset state
    #13;
    check("R1", 3'b000, 3'b000, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    enableIn = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      applyVec(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][10:8], VEC[i][7:5], VEC[i][4]);
      nChecks++; // R13 on every vector
      if ((topDrv & botDrv) != 3'b000) begin
        nFail++;
        $display("FAIL R13 vec%0d: top=%b bot=%b expected no shared phase", i, topDrv, botDrv);
      end
    end

    // R2: output holds until the next rising edge
    @(negedge clk); applyVec(VEC[0]);
    @(negedge clk); applyVec(VEC[2]);
    #1 check("R2 before edge", 3'b001, 3'b010, 1'b1);
    @(negedge clk);
    check("R2 after edge", 3'b010, 3'b100, 1'b1);

    // R6: pwm toggles bottom only
    pwmGate = 1'b0;
    @(negedge clk); check("R6 chop off", 3'b010, 3'b000, 1'b1);
    pwmGate = 1'b1;
    @(negedge clk); check("R6 chop on", 3'b010, 3'b100, 1'b1);

    // R12: clearing external fault restores commutation
    extFault = 1'b1;
    @(negedge clk); check("R12 assert", 3'b010, 3'b000, 1'b0);
    extFault = 1'b0;
    @(negedge clk); check("R12 release", 3'b010, 3'b100, 1'b1);

    // R1: reset mid-run
    rst_n = 1'b0; #1;
    check("R1 async", 3'b000, 3'b000, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R3 after reset", 3'b010, 3'b100, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule